// File: doc/BRIEF.md
# E-paper panel command sequencer

This block drives a serial e-paper panel controller from the host side. It owns the SPI clock, data-out and chip-select pins, the data/command select line and the panel's hardware reset line, and it watches the panel's BUSY output. A start strobe with a two-bit selector picks one of four stored sequences. The block then plays the chosen sequence entry by entry. Each entry is a command byte, a data byte, a millisecond delay, a wait on BUSY, a bulk pixel transfer, or the end marker. When the sequence is finished, the block pulses `done`.

The power-up sequence begins with a timed hardware reset pulse. After that it sends the software reset command, waits for BUSY, and writes the panel setup and the full-screen RAM window. A bulk entry keeps chip-select low and takes pixel bytes from an external stream with a valid/ready handshake until a byte marked last has been shifted out. Each BUSY wait has a millisecond timeout. If the timeout expires, the sequence is aborted and `timed_out` is raised. A prescaler derives all delays from the system clock, and the bench shortens it through a parameter.

Top module: `epd_seq_engine`

## Requirements
- R1: SPI runs in mode 0 with the most significant bit first. `spi_sclk` is low whenever `spi_cs_n` is high. `spi_mosi` does not change while `spi_sclk` is high.
- R2: A command byte is shifted with `epd_dc` low inside its own chip-select frame. Afterwards `spi_cs_n` and `epd_dc` return high. `epd_dc` never changes while `spi_cs_n` stays low.
- R3: A data byte of a stored sequence is shifted with `epd_dc` high inside its own chip-select frame.
- R4: A bulk entry holds `spi_cs_n` low and `epd_dc` high across every stream byte until the byte that carried `pix_last` has been sent. `pix_ready` is high only while the block can take a stream byte.
- R5: `seq_sel` = 0 selects the power-up sequence. It first holds `epd_rst_n` high for RST_HI_MS ms, then low for RST_LO_MS ms, then high for RST_HI_MS ms before the first SPI byte.
- R6: The power-up bytes, command (C) or data (D), in order, are: C12, C18 D80, C0C DAE DC7 DC3 DC0 D40, C01 DDF D01 D02, C3C D01, C11 D03, C44 D00 D00 D1F D03, C45 D00 D00 DDF D01, C4E D00 D00, C4F D00 D00.
- R7: After command 0x12 the block lets 10 ms pass with no SPI traffic before it starts to wait on BUSY.
- R8: A BUSY wait (after 0x12 and after 0x20) ends only once `epd_busy` is low. No later byte is sent and `done` is not raised while BUSY is high.
- R9: If `epd_busy` stays high for BUSY_TMO_MS ms of a wait, the rest of the sequence is skipped and `done` pulses with `timed_out` high. `timed_out` holds until the next accepted start.
- R10: `seq_sel` = 1 (refresh) sends C22 DF7 C20 and then waits on BUSY. `seq_sel` = 3 (power off) sends C22 D83 C20 and then waits on BUSY.
- R11: `done` is a single-cycle pulse at the end of a sequence. A `start` that arrives while a sequence runs is ignored.
- R12: `seq_sel` = 2 (buffer write) sends command 0x24 in its own frame, followed by one bulk frame of stream bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start strobe, taken only when idle |
| seq_sel | input | 2 | Sequence selector: 0 power-up, 1 refresh, 2 buffer write, 3 power off |
| pix_valid | input | 1 | Stream byte valid |
| pix_data | input | 8 | Stream byte |
| pix_last | input | 1 | Marks the final stream byte of a bulk frame |
| pix_ready | output | 1 | Block takes a stream byte this cycle if valid |
| epd_busy | input | 1 | Panel BUSY, active high, asynchronous |
| spi_sclk | output | 1 | SPI clock |
| spi_mosi | output | 1 | SPI data out |
| spi_cs_n | output | 1 | SPI chip select, active low |
| epd_dc | output | 1 | Data/command select, low for commands |
| epd_rst_n | output | 1 | Panel hardware reset, active low |
| done | output | 1 | One-cycle end-of-sequence pulse |
| timed_out | output | 1 | Last sequence ended on a BUSY timeout |

## Verification
All four sequences are played. The bench decodes the SPI pins back into command and data bytes and numbers the chip-select frames, so it can tell a command framed on its own apart from a byte sitting in a bulk frame. BUSY is given three profiles:
- A long pulse shows that the block waits on the pin and not on a fixed delay.
- A short pulse exposes the 10 ms gap after software reset.
- A BUSY that never falls exercises the timeout and the abort.

A second start issued while a refresh is running checks that the request is ignored. A five-byte stream with the last flag on its final byte checks bulk framing.

// File: rtl/epd_seq_pkg.sv
package epd_seq_pkg;

  localparam int unsigned IDX_W   = 6;
  localparam int unsigned PANEL_W = 800;
  localparam int unsigned PANEL_H = 480;

  localparam logic [1:0] SEL_INIT    = 2'd0;
  localparam logic [1:0] SEL_REFRESH = 2'd1;
  localparam logic [1:0] SEL_WRITE   = 2'd2;
  localparam logic [1:0] SEL_PWROFF  = 2'd3;

  localparam logic [7:0] MASK_REFRESH = 8'hF7;
  localparam logic [7:0] MASK_PWROFF  = 8'h83;
  localparam logic [7:0] SWRST_WAIT_MS = 8'd10;

  typedef enum logic [2:0] {
    ET_CMD, ET_DATA, ET_DELAY, ET_WAITB, ET_BULK, ET_END
  } ent_kind_e;

  typedef struct packed {
    ent_kind_e  kind;
    logic [7:0] arg;
  } seq_ent_t;

  function automatic logic [7:0] lo8(input int unsigned v);
    return v[7:0];
  endfunction

  function automatic logic [7:0] hi8(input int unsigned v);
    return v[15:8];
  endfunction

  function automatic seq_ent_t mk(input ent_kind_e k, input logic [7:0] a);
    seq_ent_t e;
    e.kind = k;
    e.arg  = a;
    return e;
  endfunction

  // Power-up list: reset, setup, full-screen RAM window.
  function automatic seq_ent_t init_entry(input logic [IDX_W-1:0] i);
    case (i)
      6'd0:  return mk(ET_CMD,   8'h12);
      6'd1:  return mk(ET_DELAY, SWRST_WAIT_MS);
      6'd2:  return mk(ET_WAITB, 8'h00);
      6'd3:  return mk(ET_CMD,   8'h18);
      6'd4:  return mk(ET_DATA,  8'h80);
      6'd5:  return mk(ET_CMD,   8'h0C);
      6'd6:  return mk(ET_DATA,  8'hAE);
      6'd7:  return mk(ET_DATA,  8'hC7);
      6'd8:  return mk(ET_DATA,  8'hC3);
      6'd9:  return mk(ET_DATA,  8'hC0);
      6'd10: return mk(ET_DATA,  8'h40);
      6'd11: return mk(ET_CMD,   8'h01);
      6'd12: return mk(ET_DATA,  lo8(PANEL_H - 1));
      6'd13: return mk(ET_DATA,  hi8(PANEL_H - 1));
      6'd14: return mk(ET_DATA,  8'h02);
      6'd15: return mk(ET_CMD,   8'h3C);
      6'd16: return mk(ET_DATA,  8'h01);
      6'd17: return mk(ET_CMD,   8'h11);
      6'd18: return mk(ET_DATA,  8'h03);
      6'd19: return mk(ET_CMD,   8'h44);
      6'd20: return mk(ET_DATA,  8'h00);
      6'd21: return mk(ET_DATA,  8'h00);
      6'd22: return mk(ET_DATA,  lo8(PANEL_W - 1));
      6'd23: return mk(ET_DATA,  hi8(PANEL_W - 1));
      6'd24: return mk(ET_CMD,   8'h45);
      6'd25: return mk(ET_DATA,  8'h00);
      6'd26: return mk(ET_DATA,  8'h00);
      6'd27: return mk(ET_DATA,  lo8(PANEL_H - 1));
      6'd28: return mk(ET_DATA,  hi8(PANEL_H - 1));
      6'd29: return mk(ET_CMD,   8'h4E);
      6'd30: return mk(ET_DATA,  8'h00);
      6'd31: return mk(ET_DATA,  8'h00);
      6'd32: return mk(ET_CMD,   8'h4F);
      6'd33: return mk(ET_DATA,  8'h00);
      6'd34: return mk(ET_DATA,  8'h00);
      default: return mk(ET_END, 8'h00);
    endcase
  endfunction

  // Update trigger: mask, activate, wait.
  function automatic seq_ent_t update_entry(input logic [IDX_W-1:0] i,
                                            input logic [7:0] mask);
    case (i)
      6'd0: return mk(ET_CMD,   8'h22);
      6'd1: return mk(ET_DATA,  mask);
      6'd2: return mk(ET_CMD,   8'h20);
      6'd3: return mk(ET_WAITB, 8'h00);
      default: return mk(ET_END, 8'h00);
    endcase
  endfunction

  function automatic seq_ent_t write_entry(input logic [IDX_W-1:0] i);
    case (i)
      6'd0: return mk(ET_CMD,  8'h24);
      6'd1: return mk(ET_BULK, 8'h00);
      default: return mk(ET_END, 8'h00);
    endcase
  endfunction

  function automatic seq_ent_t seq_lookup(input logic [1:0] sel,
                                          input logic [IDX_W-1:0] i);
    case (sel)
      SEL_INIT:    return init_entry(i);
      SEL_REFRESH: return update_entry(i, MASK_REFRESH);
      SEL_WRITE:   return write_entry(i);
      default:     return update_entry(i, MASK_PWROFF);
    endcase
  endfunction

endpackage

// File: rtl/epd_seq_rom.sv
module epd_seq_rom
  import epd_seq_pkg::*;
(
  input  logic [1:0]       sel,
  input  logic [IDX_W-1:0] idx,
  output seq_ent_t         ent
);
  assign ent = seq_lookup(sel, idx);
endmodule

// File: rtl/epd_ms_tick.sv
module epd_ms_tick #(
  parameter int unsigned TICKS_PER_MS = 50000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  output logic tick
);
  localparam int unsigned CW = (TICKS_PER_MS > 2) ? $clog2(TICKS_PER_MS) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICKS_PER_MS - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (clr) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt == LAST) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + 1'b1;
      tick <= 1'b0;
    end
  end
endmodule

// File: rtl/epd_spi_byte.sv
module epd_spi_byte #(
  parameter int unsigned HALF_CYC = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       go,
  input  logic [7:0] din,
  output logic       sclk,
  output logic       mosi,
  output logic       done
);
  localparam int unsigned CW = (HALF_CYC > 2) ? $clog2(HALF_CYC) : 1;
  localparam logic [CW-1:0] PH_LAST = CW'(HALF_CYC - 1);

  logic          active;
  logic [CW-1:0] ph;
  logic [2:0]    bitn;
  logic [7:0]    sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      ph     <= '0;
      bitn   <= '0;
      sh     <= '0;
      sclk   <= 1'b0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!active) begin
        if (go) begin
          sh     <= din;
          active <= 1'b1;
          bitn   <= '0;
          ph     <= '0;
          sclk   <= 1'b0;
        end
      end else if (ph == PH_LAST) begin
        ph <= '0;
        if (!sclk) begin
          sclk <= 1'b1;
        end else begin
          sclk <= 1'b0;
          if (bitn == 3'd7) begin
            active <= 1'b0;
            done   <= 1'b1;
          end else begin
            bitn <= bitn + 3'd1;
            sh   <= {sh[6:0], 1'b0};
          end
        end
      end else begin
        ph <= ph + 1'b1;
      end
    end
  end

  assign mosi = sh[7];
endmodule

// File: rtl/epd_seq_engine.sv
module epd_seq_engine
  import epd_seq_pkg::*;
#(
  parameter int unsigned TICKS_PER_MS = 50000,
  parameter int unsigned SCLK_HALF    = 2,
  parameter int unsigned RST_HI_MS    = 20,
  parameter int unsigned RST_LO_MS    = 2,
  parameter int unsigned BUSY_TMO_MS  = 10000,
  parameter int unsigned SETTLE_CYC   = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [1:0] seq_sel,
  input  logic       pix_valid,
  input  logic [7:0] pix_data,
  input  logic       pix_last,
  output logic       pix_ready,
  input  logic       epd_busy,
  output logic       spi_sclk,
  output logic       spi_mosi,
  output logic       spi_cs_n,
  output logic       epd_dc,
  output logic       epd_rst_n,
  output logic       done,
  output logic       timed_out
);
  localparam int unsigned MS_MAX = (BUSY_TMO_MS > RST_HI_MS) ? BUSY_TMO_MS : RST_HI_MS;
  localparam int unsigned MSW    = $clog2(MS_MAX + 256);
  localparam int unsigned STW    = (SETTLE_CYC > 2) ? $clog2(SETTLE_CYC) : 1;

  typedef enum logic [3:0] {
    S_IDLE, S_RHI1, S_RLO, S_RHI2, S_FETCH, S_SEND, S_DELAY,
    S_SETTLE, S_WAITB, S_BWAIT, S_BSEND, S_FIN
  } st_e;

  st_e              state;
  logic [1:0]       sel_q;
  logic [IDX_W-1:0] idx_q;
  logic [MSW-1:0]   ms_cnt;
  logic [MSW-1:0]   ms_target;
  logic [STW-1:0]   set_cnt;
  logic [7:0]       dly_q;
  logic             last_q;
  logic             busy_m, busy_s;
  logic             tick, tick_clr, timed_state, ms_hit;
  seq_ent_t         ent;
  logic             sb_go, sb_done;
  logic [7:0]       sb_din;

  // Named events for the checker.
  logic ev_byte_done, ev_timeout, ev_busy_clear;

  epd_seq_rom u_rom (
    .sel (sel_q),
    .idx (idx_q),
    .ent (ent)
  );

  epd_ms_tick #(.TICKS_PER_MS(TICKS_PER_MS)) u_tick (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (tick_clr),
    .tick  (tick)
  );

  epd_spi_byte #(.HALF_CYC(SCLK_HALF)) u_shift (
    .clk   (clk),
    .rst_n (rst_n),
    .go    (sb_go),
    .din   (sb_din),
    .sclk  (spi_sclk),
    .mosi  (spi_mosi),
    .done  (sb_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_m <= 1'b0;
      busy_s <= 1'b0;
    end else begin
      busy_m <= epd_busy;
      busy_s <= busy_m;
    end
  end

  always_comb begin
    timed_state = (state == S_RHI1) || (state == S_RLO) || (state == S_RHI2) ||
                  (state == S_DELAY) || (state == S_WAITB);
    tick_clr = !timed_state;
    case (state)
      S_RLO:   ms_target = MSW'(RST_LO_MS);
      S_DELAY: ms_target = MSW'(dly_q);
      S_WAITB: ms_target = MSW'(BUSY_TMO_MS);
      default: ms_target = MSW'(RST_HI_MS);
    endcase
    ms_hit = tick && (ms_cnt + 1'b1 >= ms_target);
  end

  always_comb begin
    sb_go  = ((state == S_FETCH) && ((ent.kind == ET_CMD) || (ent.kind == ET_DATA))) ||
             ((state == S_BWAIT) && pix_valid);
    sb_din = (state == S_BWAIT) ? pix_data : ent.arg;
  end

  assign pix_ready     = (state == S_BWAIT);
  assign done          = (state == S_FIN);
  assign ev_byte_done  = sb_done;
  assign ev_timeout    = (state == S_WAITB) && busy_s && ms_hit;
  assign ev_busy_clear = (state == S_WAITB) && !busy_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ms_cnt <= '0;
    end else if (!timed_state || ms_hit) begin
      ms_cnt <= '0;
    end else if (tick) begin
      ms_cnt <= ms_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      sel_q     <= SEL_INIT;
      idx_q     <= '0;
      set_cnt   <= '0;
      dly_q     <= 8'd1;
      last_q    <= 1'b0;
      spi_cs_n  <= 1'b1;
      epd_dc    <= 1'b1;
      epd_rst_n <= 1'b1;
      timed_out <= 1'b0;
    end else begin
      case (state)
        S_IDLE: begin
          if (start) begin
            sel_q     <= seq_sel;
            idx_q     <= '0;
            timed_out <= 1'b0;
            state     <= (seq_sel == SEL_INIT) ? S_RHI1 : S_FETCH;
          end
        end
        S_RHI1: begin
          if (ms_hit) begin
            epd_rst_n <= 1'b0;
            state     <= S_RLO;
          end
        end
        S_RLO: begin
          if (ms_hit) begin
            epd_rst_n <= 1'b1;
            state     <= S_RHI2;
          end
        end
        S_RHI2: begin
          if (ms_hit) state <= S_FETCH;
        end
        S_FETCH: begin
          case (ent.kind)
            ET_CMD: begin
              spi_cs_n <= 1'b0;
              epd_dc   <= 1'b0;
              state    <= S_SEND;
            end
            ET_DATA: begin
              spi_cs_n <= 1'b0;
              epd_dc   <= 1'b1;
              state    <= S_SEND;
            end
            ET_DELAY: begin
              dly_q <= (ent.arg == 8'd0) ? 8'd1 : ent.arg;
              idx_q <= idx_q + 1'b1;
              state <= S_DELAY;
            end
            ET_WAITB: begin
              set_cnt <= '0;
              idx_q   <= idx_q + 1'b1;
              state   <= S_SETTLE;
            end
            ET_BULK: begin
              spi_cs_n <= 1'b0;
              epd_dc   <= 1'b1;
              idx_q    <= idx_q + 1'b1;
              state    <= S_BWAIT;
            end
            default: state <= S_FIN;
          endcase
        end
        S_SEND: begin
          if (sb_done) begin
            spi_cs_n <= 1'b1;
            epd_dc   <= 1'b1;
            idx_q    <= idx_q + 1'b1;
            state    <= S_FETCH;
          end
        end
        S_DELAY: begin
          if (ms_hit) state <= S_FETCH;
        end
        S_SETTLE: begin
          if (set_cnt == STW'(SETTLE_CYC - 1)) state <= S_WAITB;
          else set_cnt <= set_cnt + 1'b1;
        end
        S_WAITB: begin
          if (!busy_s) begin
            state <= S_FETCH;
          end else if (ms_hit) begin
            timed_out <= 1'b1;
            state     <= S_FIN;
          end
        end
        S_BWAIT: begin
          if (pix_valid) begin
            last_q <= pix_last;
            state  <= S_BSEND;
          end
        end
        S_BSEND: begin
          if (sb_done) begin
            if (last_q) begin
              spi_cs_n <= 1'b1;
              state    <= S_FETCH;
            end else begin
              state <= S_BWAIT;
            end
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/epd_seq_checker.sv
module epd_seq_checker (
  input logic clk,
  input logic rst_n,
  input logic spi_sclk,
  input logic spi_mosi,
  input logic spi_cs_n,
  input logic epd_dc,
  input logic epd_rst_n,
  input logic pix_ready,
  input logic done,
  input logic timed_out,
  input logic ev_timeout,
  input logic ev_busy_clear
);
  a_r1_sclk_low_outside_frame: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sclk);

  a_r1_mosi_hold_while_high: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_sclk && $past(spi_sclk)) |-> $stable(spi_mosi));

  a_r2_dc_steady_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
    (!spi_cs_n && $past(!spi_cs_n)) |-> $stable(epd_dc));

  a_r4_ready_only_in_bulk: assert property (@(posedge clk) disable iff (!rst_n)
    pix_ready |-> (!spi_cs_n && epd_dc));

  a_r5_quiet_during_reset: assert property (@(posedge clk) disable iff (!rst_n)
    !epd_rst_n |-> spi_cs_n);

  a_r8_release_not_done: assert property (@(posedge clk) disable iff (!rst_n)
    ev_busy_clear |=> !done);

  a_r9_timeout_ends_run: assert property (@(posedge clk) disable iff (!rst_n)
    ev_timeout |=> (done && timed_out));

  a_r11_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

bind epd_seq_engine epd_seq_checker u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .spi_sclk      (spi_sclk),
  .spi_mosi      (spi_mosi),
  .spi_cs_n      (spi_cs_n),
  .epd_dc        (epd_dc),
  .epd_rst_n     (epd_rst_n),
  .pix_ready     (pix_ready),
  .done          (done),
  .timed_out     (timed_out),
  .ev_timeout    (ev_timeout),
  .ev_busy_clear (ev_busy_clear)
);

// File: tb/tb_epd_seq_engine.sv
`timescale 1ns/1ps
module tb_epd_seq_engine;
  localparam int TPM  = 4;
  localparam int HALF = 2;
  localparam int RHI  = 20;
  localparam int RLO  = 2;
  localparam int TMO  = 100;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [1:0] seq_sel = 2'd0;
  logic pix_valid = 1'b0;
  logic [7:0] pix_data = 8'h00;
  logic pix_last = 1'b0;
  logic pix_ready;
  logic epd_busy = 1'b0;
  logic spi_sclk, spi_mosi, spi_cs_n, epd_dc, epd_rst_n, done, timed_out;

  always #10 clk = ~clk;

  epd_seq_engine #(
    .TICKS_PER_MS(TPM), .SCLK_HALF(HALF), .RST_HI_MS(RHI),
    .RST_LO_MS(RLO), .BUSY_TMO_MS(TMO), .SETTLE_CYC(16)
  ) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .seq_sel(seq_sel),
    .pix_valid(pix_valid), .pix_data(pix_data), .pix_last(pix_last),
    .pix_ready(pix_ready), .epd_busy(epd_busy), .spi_sclk(spi_sclk),
    .spi_mosi(spi_mosi), .spi_cs_n(spi_cs_n), .epd_dc(epd_dc),
    .epd_rst_n(epd_rst_n), .done(done), .timed_out(timed_out)
  );

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  bit finished = 1'b0;

  // Captured SPI traffic
  logic [7:0] cap_b [0:127];
  bit         cap_dc [0:127];
  int         cap_fr [0:127];
  int         cap_cyc [0:127];
  int         ncap = 0;
  int         frame_id = 0;
  int         mon_fr = -1;
  int         bitc = 0;
  logic [7:0] msh = 8'h00;
  int         req_cnt = 0;

  // Expected traffic
  logic [7:0] exp_b [0:63];
  bit         exp_dc [0:63];
  int         nexp = 0;

  // Pin trackers
  int  busy_len = 0;
  int  busy_seen = 0;
  int  bcnt = 0;
  int  busy_fall_cyc = 0;
  int  done_cnt = 0;
  int  done_cyc = 0;
  int  rst_falls = 0;
  int  rst_fall_cyc = 0;
  int  rst_rise_cyc = 0;
  bit  prev_rst = 1'b1;
  int  start_cyc = 0;
  int  d_base = 0;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge spi_cs_n) frame_id = frame_id + 1;

  always @(posedge spi_sclk) begin
    if (!spi_cs_n) begin
      if (frame_id != mon_fr) begin
        mon_fr = frame_id;
        bitc = 0;
      end
      msh = {msh[6:0], spi_mosi};
      bitc = bitc + 1;
      if (bitc == 8) begin
        bitc = 0;
        if (ncap < 128) begin
          cap_b[ncap] = msh;
          cap_dc[ncap] = epd_dc;
          cap_fr[ncap] = frame_id;
          cap_cyc[ncap] = cyc;
          ncap = ncap + 1;
        end
        if (!epd_dc && (msh == 8'h12 || msh == 8'h20)) req_cnt = req_cnt + 1;
      end
    end
  end

  // Panel model for BUSY plus trackers for reset and done.
  always @(negedge clk) begin
    if (req_cnt != busy_seen) begin
      busy_seen = req_cnt;
      epd_busy = 1'b1;
      bcnt = busy_len;
    end else if (epd_busy && busy_len >= 0) begin
      if (bcnt <= 0) begin
        epd_busy = 1'b0;
        busy_fall_cyc = cyc;
      end else begin
        bcnt = bcnt - 1;
      end
    end
    if (prev_rst && !epd_rst_n) begin
      rst_falls = rst_falls + 1;
      rst_fall_cyc = cyc;
    end
    if (!prev_rst && epd_rst_n) rst_rise_cyc = cyc;
    prev_rst = epd_rst_n;
    if (done) begin
      done_cnt = done_cnt + 1;
      done_cyc = cyc;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic ex(input logic [7:0] b, input bit dc);
    exp_b[nexp] = b;
    exp_dc[nexp] = dc;
    nexp++;
  endtask

  task automatic kick(input logic [1:0] s);
    @(negedge clk);
    ncap = 0;
    nexp = 0;
    d_base = done_cnt;
    seq_sel = s;
    start = 1'b1;
    start_cyc = cyc;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(input int lim, input string req);
    bit got = 1'b0;
    for (int i = 0; i < lim; i++) begin
      @(negedge clk);
      if (done_cnt > d_base) begin
        got = 1'b1;
        break;
      end
    end
    chk(got, req, "done within limit", int'(got), 1);
  endtask

  task automatic cmp_stream(input string req);
    int bad = -1;
    chk(ncap == nexp, req, "byte count", ncap, nexp);
    for (int i = 0; i < nexp && i < ncap; i++) begin
      if (bad < 0 && (cap_b[i] != exp_b[i] || cap_dc[i] != exp_dc[i])) bad = i;
    end
    if (bad >= 0)
      chk(1'b0, req, $sformatf("byte %0d value/dc (dc %0d vs %0d)", bad,
          cap_dc[bad], exp_dc[bad]), cap_b[bad], exp_b[bad]);
    else
      chk(1'b1, req, "byte values", 0, 0);
  endtask

  task automatic own_frames(input int from, input int to, input string req);
    bit ok = 1'b1;
    for (int i = from + 1; i < to; i++)
      if (cap_fr[i] == cap_fr[i-1]) ok = 1'b0;
    chk(ok, req, "each byte framed alone", int'(ok), 1);
  endtask

  task automatic build_init();
    ex(8'h12, 0);
    ex(8'h18, 0); ex(8'h80, 1);
    ex(8'h0C, 0); ex(8'hAE, 1); ex(8'hC7, 1); ex(8'hC3, 1); ex(8'hC0, 1); ex(8'h40, 1);
    ex(8'h01, 0); ex(8'hDF, 1); ex(8'h01, 1); ex(8'h02, 1);
    ex(8'h3C, 0); ex(8'h01, 1);
    ex(8'h11, 0); ex(8'h03, 1);
    ex(8'h44, 0); ex(8'h00, 1); ex(8'h00, 1); ex(8'h1F, 1); ex(8'h03, 1);
    ex(8'h45, 0); ex(8'h00, 1); ex(8'h00, 1); ex(8'hDF, 1); ex(8'h01, 1);
    ex(8'h4E, 0); ex(8'h00, 1); ex(8'h00, 1);
    ex(8'h4F, 0); ex(8'h00, 1); ex(8'h00, 1);
  endtask

  task automatic push_pix(input logic [7:0] b, input bit last);
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (pix_ready) break;
    end
    pix_valid = 1'b1;
    pix_data = b;
    pix_last = last;
    @(negedge clk);
    pix_valid = 1'b0;
    pix_last = 1'b0;
  endtask

  task automatic t_reset_state();
    chk(spi_cs_n == 1'b1, "R2", "cs_n after reset", spi_cs_n, 1);
    chk(spi_sclk == 1'b0, "R1", "sclk after reset", spi_sclk, 0);
    chk(epd_rst_n == 1'b1, "R5", "panel reset idle", epd_rst_n, 1);
    chk(done == 1'b0 && timed_out == 1'b0, "R11", "done/timed_out idle",
        int'(done) + int'(timed_out), 0);
    chk(pix_ready == 1'b0, "R4", "pix_ready idle", pix_ready, 0);
  endtask

  task automatic t_init_long_busy();
    busy_len = 120;
    kick(2'd0);
    build_init();
    wait_done(6000, "R6");
    cmp_stream("R6");
    own_frames(0, ncap, "R2");
    chk(rst_fall_cyc - start_cyc >= RHI*TPM - 1, "R5", "high time before pulse",
        rst_fall_cyc - start_cyc, RHI*TPM);
    chk((rst_rise_cyc - rst_fall_cyc >= RLO*TPM - 1) && (rst_rise_cyc - rst_fall_cyc <= RLO*TPM + 2),
        "R5", "low pulse width", rst_rise_cyc - rst_fall_cyc, RLO*TPM);
    chk(cap_cyc[0] - rst_rise_cyc >= RHI*TPM, "R5", "high time before first byte",
        cap_cyc[0] - rst_rise_cyc, RHI*TPM);
    chk(ncap > 1 && cap_cyc[1] > busy_fall_cyc, "R8", "0x18 sent after BUSY low",
        cap_cyc[1], busy_fall_cyc);
    chk(timed_out == 1'b0, "R9", "no timeout on long BUSY", timed_out, 0);
  endtask

  task automatic t_init_short_busy();
    busy_len = 2;
    kick(2'd0);
    build_init();
    wait_done(6000, "R7");
    cmp_stream("R3");
    chk(ncap > 1 && (cap_cyc[1] - cap_cyc[0] >= 10*TPM) && (cap_cyc[1] - cap_cyc[0] <= 10*TPM + 120),
        "R7", "gap after software reset", cap_cyc[1] - cap_cyc[0], 10*TPM);
  endtask

  task automatic t_update(input logic [1:0] s, input logic [7:0] mask);
    busy_len = 50;
    kick(s);
    ex(8'h22, 0); ex(mask, 1); ex(8'h20, 0);
    wait_done(3000, "R10");
    cmp_stream("R10");
    own_frames(0, ncap, "R3");
    chk(done_cyc > busy_fall_cyc, "R8", "done after BUSY low", done_cyc, busy_fall_cyc);
    @(negedge clk);
    chk(done == 1'b0, "R11", "done lasts one cycle", done, 0);
  endtask

  task automatic t_bulk();
    bit ok = 1'b1;
    busy_len = 2;
    kick(2'd2);
    ex(8'h24, 0);
    ex(8'hA5, 1); ex(8'h3C, 1); ex(8'hFF, 1); ex(8'h00, 1); ex(8'h81, 1);
    push_pix(8'hA5, 0);
    push_pix(8'h3C, 0);
    push_pix(8'hFF, 0);
    push_pix(8'h00, 0);
    push_pix(8'h81, 1);
    wait_done(2000, "R12");
    cmp_stream("R12");
    for (int i = 2; i < ncap; i++) if (cap_fr[i] != cap_fr[1]) ok = 1'b0;
    chk(ok && ncap == 6, "R4", "stream bytes share one frame", int'(ok), 1);
    chk(ncap > 1 && cap_fr[1] != cap_fr[0], "R12", "command framed apart from bulk",
        cap_fr[1], cap_fr[0] + 1);
    chk(spi_cs_n == 1'b1 && pix_ready == 1'b0, "R4", "frame closed after last",
        int'(spi_cs_n), 1);
  endtask

  task automatic t_timeout();
    busy_len = -1;
    kick(2'd0);
    wait_done(4000, "R9");
    chk(timed_out == 1'b1, "R9", "timed_out raised", timed_out, 1);
    chk(ncap == 1, "R9", "rest of sequence skipped", ncap, 1);
    chk((done_cyc - cap_cyc[0] >= TMO*TPM + 10*TPM) && (done_cyc - cap_cyc[0] <= TMO*TPM + 10*TPM + 80),
        "R9", "timeout span", done_cyc - cap_cyc[0], TMO*TPM + 10*TPM);
    busy_len = 2;
    repeat (50) @(negedge clk);
    chk(timed_out == 1'b1, "R9", "timed_out held while idle", timed_out, 1);
    busy_len = 10;
    kick(2'd1);
    wait_done(3000, "R9");
    chk(timed_out == 1'b0, "R9", "timed_out cleared by next run", timed_out, 0);
  endtask

  task automatic t_start_ignored();
    int falls0;
    busy_len = 60;
    falls0 = rst_falls;
    kick(2'd1);
    repeat (10) @(negedge clk);
    seq_sel = 2'd0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done(3000, "R11");
    repeat (300) @(negedge clk);
    chk(done_cnt - d_base == 1, "R11", "one done pulse", done_cnt - d_base, 1);
    chk(rst_falls == falls0, "R11", "no reset pulse from ignored start", rst_falls - falls0, 0);
    chk(ncap == 3, "R11", "only refresh bytes sent", ncap, 3);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual expired expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset_state();
    t_init_long_busy();
    t_init_short_busy();
    t_update(2'd1, 8'hF7);
    t_update(2'd3, 8'h83);
    t_bulk();
    t_timeout();
    t_start_ignored();
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule